// File: doc/BRIEF.md
# Frequency-Indexed Front-End Write Sequencer

This block holds a front-end control configuration and turns it into a burst of register writes each time the radio starts receiving or transmitting, or hops to a new frequency. Software fills the configuration through a simple write-only register port. It can set up to two fixed activation writes, two dynamic register addresses, and a table of up to `ROWS` rows. Each row carries two data bytes and an upper frequency limit in MHz.

A start pulse carries the current RF frequency. The block first issues the activation writes. It then walks the table from row 0 upward and takes the first row whose limit is at or above the frequency. From that row it issues the dynamic writes. Writes leave on a valid/ready address/data interface, and a one-cycle `done` pulse closes each sequence.

A deadline counter, loaded with a cycle count that software sets to match the required lead time, runs alongside the sequence. It raises `late` if the writes have not finished when the count runs out. A start pulse that arrives while a sequence is running is held and served next.

Top module: `fe_write_seq`

## Requirements
- R1: Activation writes come first, in index order (pair 0, then pair 1). Their number is the value of config register 0x00 bits [1:0], and a value of 3 counts as 2. They are issued on every start, whatever the frequency.
- R2: The table is searched from row 0 upward. The first row with frequency <= limit is selected. The block then writes that row's byte [15:8] to the first dynamic address, followed by byte [7:0] to the second dynamic address.
- R3: When both dynamic addresses are equal, only the first byte of the selected row is written, once.
- R4: With a row count of 0, no dynamic write is issued and `no_match` stays 0.
- R5: With a nonzero row count and a frequency above every used row limit, no dynamic write is issued. `no_match` reads 1 from the end of that sequence until the next sequence starts.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R7: `done` is a single-cycle pulse after the last write of every sequence. It is also raised when a sequence has no writes at all.
- R8: `late` is set when the deadline count, loaded at sequence start from config register 0x05, runs out before the sequence ends. It stays set until the next sequence starts.
- R9: A start pulse that arrives while a sequence runs is kept and served right after it, with its own frequency. Both sequences produce their full writes and a `done` pulse each.
- R10: After reset, `wr_valid`, `done`, `no_match` and `late` are 0.
- R11: Config map. 0x00 sets the activation count. 0x01 and 0x02 set activation pairs 0 and 1 as {addr[15:8], data[7:0]}. 0x03 sets the dynamic addresses as {first[15:8], second[7:0]}. 0x04 sets the row count, with values above `ROWS` clamped to `ROWS`. 0x05 sets the deadline in cycles. 0x80+i sets row i's data {first, second}. 0xC0+i sets row i's limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | AW | Config register address |
| cfg_wdata | input | FW | Config write data |
| start | input | 1 | RF start / hop pulse |
| start_freq | input | FW | Current RF frequency in MHz |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Write accepted by the bus side |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Register data of the write |
| done | output | 1 | Sequence complete pulse |
| no_match | output | 1 | Frequency above every row limit |
| late | output | 1 | Deadline expired before completion |

## Verification
The search is tried with frequencies exactly on a limit, one above it, at zero and above the last limit. This separates an inclusive comparison from an exclusive one and first-match selection from last-match selection. A full table probed at its last row checks that the walk reaches the end and stops at the row count. Runs with equal dynamic addresses, zero rows and zero activation pairs check that write dropping depends only on the configuration and not on the frequency. Stalled ready patterns, combined with a short and a long deadline, separate correct `late` timing from spurious flags. Back-to-back starts confirm that a queued frequency is replayed rather than lost.

// File: rtl/fe_write_seq.sv
module fe_write_seq #(
  parameter int ROWS = 64,
  parameter int FW   = 16,
  parameter int AW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [FW-1:0] cfg_wdata,
  input  logic          start,
  input  logic [FW-1:0] start_freq,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [7:0]    wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          no_match,
  output logic          late
);
  localparam int IW = $clog2(ROWS);
  localparam int CW = $clog2(ROWS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_SRCH, S_DYN0, S_DYN1, S_FIN} st_t;

  logic [1:0]    act_n;
  logic [7:0]    act_a [2];
  logic [7:0]    act_d [2];
  logic [7:0]    dyn_a, dyn_b;
  logic [CW-1:0] rows_f;
  logic [FW-1:0] dl_cfg;
  logic [15:0]   tab_d [ROWS];
  logic [FW-1:0] tab_l [ROWS];

  st_t           state;
  logic [CW-1:0] idx;
  logic [IW-1:0] sel;
  logic [FW-1:0] freq_q, pend_f, dl_cnt;
  logic          pend, late_q, nm_q;

  wire [CW-1:0] nrows   = (rows_f > CW'(ROWS)) ? CW'(ROWS) : rows_f;
  wire [CW-1:0] act_eff = CW'((act_n == 2'd3) ? 2'd2 : act_n);
  wire          launch  = (state == S_IDLE) && (pend || start);
  wire          running = (state == S_ACT) || (state == S_SRCH) ||
                          (state == S_DYN0) || (state == S_DYN1);
  wire          hs      = wr_valid && wr_ready;

  assign wr_valid = ((state == S_ACT) && (idx < act_eff)) ||
                    (state == S_DYN0) || (state == S_DYN1);
  assign wr_addr  = (state == S_ACT)  ? act_a[idx[0]] :
                    (state == S_DYN0) ? dyn_a : dyn_b;
  assign wr_data  = (state == S_ACT)  ? act_d[idx[0]] :
                    (state == S_DYN0) ? tab_d[sel][15:8] : tab_d[sel][7:0];
  assign done     = (state == S_FIN);
  assign no_match = nm_q;
  assign late     = late_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_n  <= '0;
      dyn_a  <= '0;
      dyn_b  <= '0;
      rows_f <= '0;
      dl_cfg <= '1;
      for (int i = 0; i < 2; i++) begin
        act_a[i] <= '0;
        act_d[i] <= '0;
      end
      for (int i = 0; i < ROWS; i++) begin
        tab_d[i] <= '0;
        tab_l[i] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_addr[AW-1:AW-2])
        2'b00: begin
          case (cfg_addr)
            AW'(0): act_n <= cfg_wdata[1:0];
            AW'(1): begin act_a[0] <= cfg_wdata[15:8]; act_d[0] <= cfg_wdata[7:0]; end
            AW'(2): begin act_a[1] <= cfg_wdata[15:8]; act_d[1] <= cfg_wdata[7:0]; end
            AW'(3): begin dyn_a <= cfg_wdata[15:8]; dyn_b <= cfg_wdata[7:0]; end
            AW'(4): rows_f <= cfg_wdata[CW-1:0];
            AW'(5): dl_cfg <= cfg_wdata;
            default: ;
          endcase
        end
        2'b10: tab_d[cfg_addr[IW-1:0]] <= cfg_wdata[15:0];
        2'b11: tab_l[cfg_addr[IW-1:0]] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      sel    <= '0;
      freq_q <= '0;
      pend   <= 1'b0;
      pend_f <= '0;
      dl_cnt <= '0;
      late_q <= 1'b0;
      nm_q   <= 1'b0;
    end else begin
      if (launch) begin
        pend   <= pend && start;
        pend_f <= start_freq;
      end else if (start) begin
        pend   <= 1'b1;
        pend_f <= start_freq;
      end

      if (running && dl_cnt != '0) dl_cnt <= dl_cnt - 1'b1;
      if (running && dl_cnt == '0) late_q <= 1'b1;

      case (state)
        S_IDLE: if (launch) begin
          freq_q <= pend ? pend_f : start_freq;
          idx    <= '0;
          dl_cnt <= dl_cfg;
          late_q <= 1'b0;
          nm_q   <= 1'b0;
          state  <= S_ACT;
        end
        S_ACT: begin
          if (idx >= act_eff) begin
            idx   <= '0;
            state <= S_SRCH;
          end else if (hs) begin
            idx <= idx + 1'b1;
          end
        end
        S_SRCH: begin
          if (idx >= nrows) begin
            nm_q  <= (nrows != '0);
            state <= S_FIN;
          end else if (freq_q <= tab_l[idx[IW-1:0]]) begin
            sel   <= idx[IW-1:0];
            state <= S_DYN0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_DYN0: if (hs) state <= (dyn_a == dyn_b) ? S_FIN : S_DYN1;
        S_DYN1: if (hs) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DYN1) |-> (dyn_b != dyn_a));

  p_row_fit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DYN0) |-> (freq_q <= tab_l[sel]));

  p_nm_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nm_q |-> !((state == S_DYN0) || (state == S_DYN1)));

  p_pend_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_FIN) && pend) |=> ##1 (state == S_ACT));
endmodule

// File: tb/fe_write_seq_tb_top.sv
module fe_write_seq_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, start = 0, wr_ready = 1;
  logic [7:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, start_freq = 0;
  logic        wr_valid, done, no_match, late;
  logic [7:0]  wr_addr, wr_data;

  fe_write_seq dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .start_freq(start_freq), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .no_match(no_match), .late(late));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, done_cnt = 0, rec_n = 0, exp_n = 0, cyc = 0;
  logic [15:0] rec [256];
  logic [15:0] expv [256];
  bit bp = 0, finished = 0;
  logic        exp_nm;

  int          sh_act_n = 0, sh_rows = 0;
  logic [15:0] sh_act [2];
  logic [7:0]  sh_da = 0, sh_db = 0;
  logic [15:0] sh_d [64];
  logic [15:0] sh_l [64];

  always @(negedge clk) begin
    if (wr_valid && wr_ready && rec_n < 256) begin rec[rec_n] = {wr_addr, wr_data}; rec_n++; end
    if (done) done_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    #1 wr_ready = !bp || (cyc % 4 == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    if (a == 8'h00) sh_act_n = (d[1:0] == 2'd3) ? 2 : int'(d[1:0]);
    else if (a == 8'h01) sh_act[0] = d;
    else if (a == 8'h02) sh_act[1] = d;
    else if (a == 8'h03) begin sh_da = d[15:8]; sh_db = d[7:0]; end
    else if (a == 8'h04) sh_rows = (d[6:0] > 64) ? 64 : int'(d[6:0]);
    else if (a[7:6] == 2'b10) sh_d[a[5:0]] = d;
    else if (a[7:6] == 2'b11) sh_l[a[5:0]] = d;
  endtask

  task automatic model(input logic [15:0] f);
    int hit = -1;
    for (int i = 0; i < sh_act_n; i++) begin expv[exp_n] = sh_act[i]; exp_n++; end
    for (int i = 0; i < sh_rows; i++)
      if (hit < 0 && f <= sh_l[i]) hit = i;
    exp_nm = (hit < 0) && (sh_rows != 0);
    if (hit >= 0) begin
      expv[exp_n] = {sh_da, sh_d[hit][15:8]}; exp_n++;
      if (sh_db != sh_da) begin expv[exp_n] = {sh_db, sh_d[hit][7:0]}; exp_n++; end
    end
  endtask

  task automatic pulse(input logic [15:0] f);
    @(posedge clk); #1;
    start = 1; start_freq = f;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_done(input int base, input int n, input string req);
    int t = 0;
    while (done_cnt < base + n && t < 3000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(done_cnt == base + n, {req, " done count"}, done_cnt - base, n);
  endtask

  task automatic compare(input string req);
    chk(rec_n == exp_n, {req, " write count"}, rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++)
      chk(rec[i] == expv[i], {req, " write"}, rec[i], expv[i]);
  endtask

  task automatic run(input logic [15:0] f, input string req);
    int base = done_cnt;
    rec_n = 0; exp_n = 0;
    model(f);
    pulse(f);
    wait_done(base, 1, req);
    compare(req);
    chk(no_match == exp_nm, {req, " no_match"}, no_match, exp_nm);
  endtask

  task automatic t_reset;
    chk(!wr_valid, "R10 wr_valid", wr_valid, 0);
    chk(!done, "R10 done", done, 0);
    chk(!no_match, "R10 no_match", no_match, 0);
    chk(!late, "R10 late", late, 0);
  endtask

  task automatic t_basic;
    cfg(8'h05, 16'd1000);
    cfg(8'h00, 16'd1);
    cfg(8'h01, 16'h1C38);
    cfg(8'h03, 16'h0102);
    cfg(8'h04, 16'd3);
    cfg(8'h80, 16'hAABB); cfg(8'hC0, 16'd800);
    cfg(8'h81, 16'hCCDD); cfg(8'hC1, 16'd1600);
    cfg(8'h82, 16'hEEFF); cfg(8'hC2, 16'd2200);
    run(16'd800,  "R2 R11 on limit");
    run(16'd801,  "R2 above limit");
    run(16'd0,    "R1 R2 zero freq");
    run(16'd2200, "R2 last row");
    run(16'd2201, "R5 above all");
    chk(no_match, "R5 flag held", no_match, 1);
    run(16'd1000, "R5 clears");
    chk(!late, "R8 no late", late, 0);
  endtask

  task automatic t_two_act;
    cfg(8'h02, 16'h2A5A);
    cfg(8'h00, 16'd3);
    run(16'd1700, "R1 two pairs clamp");
    cfg(8'h00, 16'd2);
    run(16'd100, "R1 two pairs");
  endtask

  task automatic t_same;
    cfg(8'h03, 16'h0505);
    run(16'd1200, "R3 same addr");
    run(16'd5000, "R3 R5 same addr nomatch");
    cfg(8'h03, 16'h0102);
  endtask

  task automatic t_zero;
    cfg(8'h04, 16'd0);
    run(16'd10, "R4 zero rows");
    cfg(8'h00, 16'd0);
    run(16'd10, "R7 empty sequence");
    cfg(8'h00, 16'd1);
    cfg(8'h04, 16'd3);
  endtask

  task automatic t_late;
    bp = 1;
    cfg(8'h05, 16'd3);
    run(16'd1601, "R6 R8 stalled");
    chk(late, "R8 late set", late, 1);
    bp = 0;
    cfg(8'h05, 16'd1000);
    run(16'd1601, "R8 clears");
    chk(!late, "R8 late cleared", late, 0);
  endtask

  task automatic t_queue;
    int base = done_cnt;
    rec_n = 0; exp_n = 0;
    model(16'd500);
    model(16'd2000);
    pulse(16'd500);
    repeat (1) @(posedge clk);
    pulse(16'd2000);
    wait_done(base, 2, "R9 queued");
    compare("R9 queued");
  endtask

  task automatic t_full;
    for (int i = 0; i < 64; i++) begin
      cfg(8'h80 + 8'(i), {8'(i), 8'(i + 100)});
      cfg(8'hC0 + 8'(i), 16'(100 * (i + 1)));
    end
    cfg(8'h04, 16'd100);
    run(16'd6400, "R2 R11 full last row");
    run(16'd6401, "R5 full above");
    run(16'd150,  "R2 full row1");
  endtask

  task automatic finish_sim;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_two_act();
    t_same();
    t_zero();
    t_late();
    t_queue();
    t_full();
    repeat (5) @(posedge clk);
    finish_sim();
  end
endmodule